// File: doc/BRIEF.md
# UART Interrupt Prioritizer and Identifier

This block collects the pending interrupt conditions of one FIFO-buffered UART channel, keeps the sticky ones, and reports the single most urgent enabled one as a 6-bit identification code. Its inputs are level conditions and one-cycle event pulses from the receiver, the transmitter, the modem-status logic and the flow-control logic. It also takes a 6-bit interrupt-enable word and one-cycle strobes that mark reads and writes of the channel's registers. It drives the identification code, a "nothing pending" flag and an active-high interrupt line.

Each sticky condition has its own clearing rule. Some conditions clear on a read of the line-status, receive-holding or modem-status register. The transmit-holding-register-empty condition clears on a write to that register. The Xoff condition clears on a received Xon. Two conditions clear only when an identification read returns their own code. The enable word masks only what is reported. Conditions still latch while their enable bit is clear and appear as soon as the bit is set.

Top module: `uart_irq_id`

## Requirements
- R1: After a synchronous reset all sticky conditions are clear, `irq_id` is 6'h01, `irq_none` is 1 and `irq_o` is 0.
- R2: A line-status condition is pending while `rx_err_level` is 1, or after an `overrun_evt` pulse until an `lsr_rd` strobe. When enabled by `ier[2]` it reports 6'h06 and beats every other source.
- R3: An `rx_timeout_evt` pulse sets a sticky timeout condition that an `rhr_rd` strobe clears. When enabled by `ier[0]` it reports 6'h0C and is reported ahead of the data-ready code.
- R4: While `rx_ready` is 1 and `ier[0]` is 1, with no line-status or timeout condition reported, the code is 6'h04.
- R5: A `thr_empty_evt` pulse sets a sticky condition, enabled by `ier[1]`, with code 6'h02. A `thr_wr` strobe clears it. An `iir_rd` strobe clears it only in a cycle where `irq_id` is 6'h02.
- R6: A cycle with any bit of `msr_delta` set latches a modem condition, enabled by `ier[3]`, with code 6'h00. An `msr_rd` strobe clears it.
- R7: An `xoff_evt` or `special_evt` pulse latches a flow-character condition, enabled by `ier[4]`, with code 6'h10. The Xoff cause clears only on `xon_evt`. The special-character cause clears only on `lsr_rd`. The code stays until both causes are clear.
- R8: A `flow_inactive_evt` pulse latches a condition, enabled by `ier[5]`, with code 6'h20. An `iir_rd` strobe clears it only in a cycle where `irq_id` is 6'h20.
- R9: Sticky conditions latch whatever the enable word is. With all enable bits 0 the block reports 6'h01 and `irq_o` is 0. Setting the enable bit later exposes the latched condition.
- R10: The priority order is: line status, timeout, data ready, THR empty, modem, flow character, flow inactive. The code of the first enabled pending source in this order is reported.
- R11: `irq_o` is 1 exactly when some enabled source is pending. `irq_none` is its inverse. The code is 6'h01 whenever nothing is pending. The outputs follow the sticky state with no extra register, so `irq_o` falls on the clock edge that clears the last source.
- R12: When a set event and a clear strobe for the same sticky condition meet in one cycle, the condition is pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier | input | 6 | Enables: [0] receive data/timeout, [1] THR empty, [2] line status, [3] modem, [4] flow character, [5] flow inactive |
| rx_err_level | input | 1 | Some character in the receive FIFO carries an error |
| overrun_evt | input | 1 | Receive overrun pulse |
| rx_timeout_evt | input | 1 | Stale receive data timeout pulse |
| rx_ready | input | 1 | Receive data ready or FIFO at trigger level |
| thr_empty_evt | input | 1 | THR empty or TX FIFO crossed its trigger pulse |
| msr_delta | input | 4 | Modem status change bits |
| xoff_evt | input | 1 | Xoff character received pulse |
| special_evt | input | 1 | Special character received pulse |
| xon_evt | input | 1 | Xon character received pulse |
| flow_inactive_evt | input | 1 | RTS or CTS went from active to inactive pulse |
| iir_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| rhr_rd | input | 1 | Receive holding register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| irq_id | output | 6 | Identification code |
| irq_none | output | 1 | No enabled interrupt pending |
| irq_o | output | 1 | Interrupt line, active high |

## Verification
The main sweep raises every one of the 128 subsets of the seven sources together under each of the 64 enable words. This separates a wrong priority rank, a wrong code and a wrong enable mapping, because each subset has its own winner under each mask. After each pattern a bulk clear is followed by an identification read, and nothing may remain pending; a clearing rule that fails shows up here. Directed sequences then cover the conditional clears: an identification read that must not clear THR-empty while a higher code is shown, Xon clearing one of two flow-character causes, a set racing a clear, and latching while disabled.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int unsigned ID_W   = 6;
    localparam int unsigned IER_W  = 6;
    localparam int unsigned NPRIO  = 7;
    localparam int unsigned NSTICK = 7;
    localparam int unsigned MSR_W  = 4;

    localparam logic [ID_W-1:0] ID_NONE = 6'h01;
    localparam logic [ID_W-1:0] ID_LINE = 6'h06;
    localparam logic [ID_W-1:0] ID_TOUT = 6'h0C;
    localparam logic [ID_W-1:0] ID_RXD  = 6'h04;
    localparam logic [ID_W-1:0] ID_THRE = 6'h02;
    localparam logic [ID_W-1:0] ID_MDM  = 6'h00;
    localparam logic [ID_W-1:0] ID_XCHR = 6'h10;
    localparam logic [ID_W-1:0] ID_FLOW = 6'h20;

    // priority rank, 0 is most urgent
    typedef enum int unsigned {
        P_LINE = 0,
        P_TOUT = 1,
        P_RXD  = 2,
        P_THRE = 3,
        P_MDM  = 4,
        P_XCHR = 5,
        P_FLOW = 6
    } prio_e;

    // sticky flag slots
    typedef enum int unsigned {
        S_OVR  = 0,
        S_TOUT = 1,
        S_THRE = 2,
        S_MDM  = 3,
        S_XOFF = 4,
        S_SPEC = 5,
        S_FLOW = 6
    } stick_e;

    typedef struct packed {
        logic flow;
        logic xchr;
        logic modem;
        logic line;
        logic thre;
        logic rxd;
    } ier_t;

    function automatic logic [ID_W-1:0] prio_code(input int unsigned rank);
        logic [ID_W-1:0] c;
        case (rank)
            P_LINE:  c = ID_LINE;
            P_TOUT:  c = ID_TOUT;
            P_RXD:   c = ID_RXD;
            P_THRE:  c = ID_THRE;
            P_MDM:   c = ID_MDM;
            P_XCHR:  c = ID_XCHR;
            P_FLOW:  c = ID_FLOW;
            default: c = ID_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] clr_v,
    output logic [N-1:0] q
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)
                    q[i] <= 1'b0;
                else if (set_v[i])
                    q[i] <= 1'b1;
                else if (clr_v[i])
                    q[i] <= 1'b0;
            end

            // R12
            set_wins_chk: assert property (@(posedge clk) disable iff (rst)
                set_v[i] |=> q[i]);
        end
    endgenerate

endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
    import uart_irq_pkg::*;
#(
    parameter int unsigned NSRC = NPRIO
) (
    input  logic [NSRC-1:0] req,
    output logic [ID_W-1:0] id,
    output logic            none
);

    logic [NSRC:0]   blk;
    logic [NSRC-1:0] gnt;

    assign blk[0] = 1'b0;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_chain
            assign blk[i+1] = blk[i] | req[i];
            assign gnt[i]   = req[i] & ~blk[i];
        end
    endgenerate

    always_comb begin
        id = ID_NONE;
        for (int unsigned i = 0; i < NSRC; i++) begin
            if (gnt[i])
                id = prio_code(i);
        end
    end

    assign none = ~blk[NSRC];

endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IER_W-1:0] ier,
    input  logic             rx_err_level,
    input  logic             overrun_evt,
    input  logic             rx_timeout_evt,
    input  logic             rx_ready,
    input  logic             thr_empty_evt,
    input  logic [MSR_W-1:0] msr_delta,
    input  logic             xoff_evt,
    input  logic             special_evt,
    input  logic             xon_evt,
    input  logic             flow_inactive_evt,
    input  logic             iir_rd,
    input  logic             lsr_rd,
    input  logic             rhr_rd,
    input  logic             msr_rd,
    input  logic             thr_wr,
    output logic [ID_W-1:0]  irq_id,
    output logic             irq_none,
    output logic             irq_o
);

    ier_t              en;
    logic [NSTICK-1:0] st_set;
    logic [NSTICK-1:0] st_clr;
    logic [NSTICK-1:0] st_q;
    logic [NPRIO-1:0]  req;

    assign en = ier_t'(ier);

    always_comb begin
        st_set          = '0;
        st_set[S_OVR]   = overrun_evt;
        st_set[S_TOUT]  = rx_timeout_evt;
        st_set[S_THRE]  = thr_empty_evt;
        st_set[S_MDM]   = |msr_delta;
        st_set[S_XOFF]  = xoff_evt;
        st_set[S_SPEC]  = special_evt;
        st_set[S_FLOW]  = flow_inactive_evt;

        st_clr          = '0;
        st_clr[S_OVR]   = lsr_rd;
        st_clr[S_TOUT]  = rhr_rd;
        st_clr[S_THRE]  = thr_wr | (iir_rd && irq_id == ID_THRE);
        st_clr[S_MDM]   = msr_rd;
        st_clr[S_XOFF]  = xon_evt;
        st_clr[S_SPEC]  = lsr_rd;
        st_clr[S_FLOW]  = iir_rd && irq_id == ID_FLOW;
    end

    uart_irq_sticky #(.N(NSTICK)) u_sticky (
        .clk   (clk),
        .rst   (rst),
        .set_v (st_set),
        .clr_v (st_clr),
        .q     (st_q)
    );

    always_comb begin
        req         = '0;
        req[P_LINE] = en.line  & (rx_err_level | st_q[S_OVR]);
        req[P_TOUT] = en.rxd   & st_q[S_TOUT];
        req[P_RXD]  = en.rxd   & rx_ready;
        req[P_THRE] = en.thre  & st_q[S_THRE];
        req[P_MDM]  = en.modem & st_q[S_MDM];
        req[P_XCHR] = en.xchr  & (st_q[S_XOFF] | st_q[S_SPEC]);
        req[P_FLOW] = en.flow  & st_q[S_FLOW];
    end

    uart_irq_arb #(.NSRC(NPRIO)) u_arb (
        .req  (req),
        .id   (irq_id),
        .none (irq_none)
    );

    assign irq_o = ~irq_none;

    // R11
    none_code_chk: assert property (@(posedge clk) disable iff (rst)
        irq_none |-> irq_id == ID_NONE);

    // R2
    line_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (en.line && rx_err_level) |-> irq_id == ID_LINE);

    // R5
    thr_wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (thr_wr && !thr_empty_evt) |=> irq_id != ID_THRE);

    // R6
    msr_rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (msr_rd && msr_delta == '0) |=> irq_id != ID_MDM);

    // R3
    tout_rank_chk: assert property (@(posedge clk) disable iff (rst)
        (en.rxd && st_q[S_TOUT]) |-> (irq_id == ID_TOUT || irq_id == ID_LINE));

    // R8
    flow_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (iir_rd && irq_id == ID_FLOW && !flow_inactive_evt) |=> irq_id != ID_FLOW);

endmodule

// File: tb/uart_irq_id_bench.sv
module uart_irq_id_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] ier = '0;
    logic       rx_err_level = 0, overrun_evt = 0, rx_timeout_evt = 0, rx_ready = 0;
    logic       thr_empty_evt = 0, xoff_evt = 0, special_evt = 0, xon_evt = 0;
    logic       flow_inactive_evt = 0;
    logic [3:0] msr_delta = '0;
    logic       iir_rd = 0, lsr_rd = 0, rhr_rd = 0, msr_rd = 0, thr_wr = 0;
    logic [5:0] irq_id;
    logic       irq_none, irq_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    uart_irq_id u_uart_irq_id (
        .clk(clk), .rst(rst), .ier(ier),
        .rx_err_level(rx_err_level), .overrun_evt(overrun_evt),
        .rx_timeout_evt(rx_timeout_evt), .rx_ready(rx_ready),
        .thr_empty_evt(thr_empty_evt), .msr_delta(msr_delta),
        .xoff_evt(xoff_evt), .special_evt(special_evt), .xon_evt(xon_evt),
        .flow_inactive_evt(flow_inactive_evt),
        .iir_rd(iir_rd), .lsr_rd(lsr_rd), .rhr_rd(rhr_rd),
        .msr_rd(msr_rd), .thr_wr(thr_wr),
        .irq_id(irq_id), .irq_none(irq_none), .irq_o(irq_o)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            report();
        end
    end

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic chk_out(string tag, logic [5:0] exp);
        chk({tag, " id"}, irq_id, exp);
        chk({tag, " none"}, irq_none, exp == 6'h01);
        chk({tag, " irq"}, irq_o, exp != 6'h01);
    endtask

    // bring every pulse low, one cycle later
    task automatic tick();
        @(negedge clk);
        overrun_evt = 0; rx_timeout_evt = 0; thr_empty_evt = 0; msr_delta = '0;
        xoff_evt = 0; special_evt = 0; xon_evt = 0; flow_inactive_evt = 0;
        iir_rd = 0; lsr_rd = 0; rhr_rd = 0; msr_rd = 0; thr_wr = 0;
    endtask

    // m: [0] overrun [1] timeout [2] rx_ready [3] thr [4] modem [5] xoff [6] flow
    function automatic logic [5:0] exp_code(logic [6:0] m, logic [5:0] e);
        if (m[0] && e[2]) return 6'h06;
        if (m[1] && e[0]) return 6'h0C;
        if (m[2] && e[0]) return 6'h04;
        if (m[3] && e[1]) return 6'h02;
        if (m[4] && e[3]) return 6'h00;
        if (m[5] && e[4]) return 6'h10;
        if (m[6] && e[5]) return 6'h20;
        return 6'h01;
    endfunction

    task automatic clear_all();
        rx_ready = 0; lsr_rd = 1; rhr_rd = 1; thr_wr = 1; msr_rd = 1; xon_evt = 1;
        ier = 6'h3F;
        tick();
        iir_rd = 1;
        tick();
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        ier = 6'h3F;
        @(negedge clk);
        chk_out("R1 reset", 6'h01);

        // sweep: R10 R11 R3 R4 R9
        for (int m = 0; m < 128; m++) begin
            for (int e = 0; e < 64; e++) begin
                ier = e[5:0];
                overrun_evt = m[0]; rx_timeout_evt = m[1]; rx_ready = m[2];
                thr_empty_evt = m[3]; msr_delta = m[4] ? (4'b0001 << (e % 4)) : 4'b0000;
                xoff_evt = m[5]; flow_inactive_evt = m[6];
                tick();
                chk_out("R10 sweep", exp_code(m[6:0], e[5:0]));
                clear_all();
                chk("R11 cleared none", irq_none, 1);
            end
        end

        // R2 level error, then overrun sticky cleared by lsr read
        rx_err_level = 1; thr_empty_evt = 1;
        tick();
        chk_out("R2 level", 6'h06);
        rx_err_level = 0;
        #0;
        @(negedge clk);
        chk_out("R2 level gone", 6'h02);
        thr_wr = 1; overrun_evt = 1;
        tick();
        chk_out("R2 overrun", 6'h06);
        lsr_rd = 1;
        tick();
        chk_out("R2 lsr clear", 6'h01);

        // R5 identification read only clears when THR code shown
        overrun_evt = 1; thr_empty_evt = 1;
        tick();
        iir_rd = 1;
        tick();
        chk_out("R5 read under line", 6'h06);
        lsr_rd = 1;
        tick();
        chk_out("R5 exposed", 6'h02);
        iir_rd = 1;
        tick();
        chk_out("R5 read clears", 6'h01);

        // R3 timeout over data ready, rhr read
        rx_ready = 1; rx_timeout_evt = 1;
        tick();
        chk_out("R3 timeout first", 6'h0C);
        rhr_rd = 1;
        tick();
        chk_out("R4 data ready", 6'h04);
        rx_ready = 0;
        @(negedge clk);
        chk_out("R4 idle", 6'h01);

        // R6 modem
        msr_delta = 4'b1000;
        tick();
        chk_out("R6 modem", 6'h00);
        msr_rd = 1;
        tick();
        chk_out("R6 msr clear", 6'h01);

        // R7 two causes
        xoff_evt = 1; special_evt = 1;
        tick();
        chk_out("R7 both", 6'h10);
        xon_evt = 1;
        tick();
        chk_out("R7 xon keeps special", 6'h10);
        lsr_rd = 1;
        tick();
        chk_out("R7 lsr clear", 6'h01);
        special_evt = 1;
        tick();
        xon_evt = 1;
        tick();
        chk_out("R7 xon ignores special", 6'h10);
        lsr_rd = 1;
        tick();
        xoff_evt = 1;
        tick();
        lsr_rd = 1;
        tick();
        chk_out("R7 lsr ignores xoff", 6'h10);
        xon_evt = 1;
        tick();
        chk_out("R7 xon clear", 6'h01);

        // R8 flow inactive behind THR
        flow_inactive_evt = 1; thr_empty_evt = 1;
        tick();
        chk_out("R8 thr above", 6'h02);
        iir_rd = 1;
        tick();
        chk_out("R8 exposed", 6'h20);
        iir_rd = 1;
        tick();
        chk_out("R8 read clears", 6'h01);

        // R12 set beats clear
        thr_empty_evt = 1; thr_wr = 1;
        tick();
        chk_out("R12 set wins", 6'h02);
        thr_wr = 1;
        tick();

        // R9 latched while disabled
        ier = 6'h00; flow_inactive_evt = 1;
        tick();
        chk_out("R9 disabled", 6'h01);
        ier = 6'h20;
        @(negedge clk);
        chk_out("R9 enabled later", 6'h20);
        iir_rd = 1;
        tick();
        chk_out("R9 cleared", 6'h01);

        report();
    end

endmodule